// File: doc/BRIEF.md
# Password-Gated Paged Register Access Controller

This block sits behind a two-wire serial slave that has already turned bus traffic into byte requests. Each request carries the device address the host used, an 8-bit register offset, a write flag and a data byte. The controller decides whether the request is addressed to this device, which physical storage it reaches and whether the current access level allows the operation. Each answer comes back one clock later.

The lower half of the offset range is flat. The upper half is paged by a table select byte held at offset 7Fh. A 32-bit entry register, which the host can write but never read, is compared on every cycle with two stored passwords to give one of three access levels. Two configuration bits change the addressing. One folds the separate 128-byte auxiliary device into the paged space of the main device. The other replaces the default main device address with a programmable byte. Storage is modelled as internal register arrays. Nonvolatile timing and bit-level bus handling belong to other blocks.

Top module: `pw_paged_regs`

## Requirements
- R1: The main device answers when dev_addr[7:1] matches A2h[7:1] while bit 4 of configuration byte 89h is 0, and matches configuration byte 8Ch[7:1] while that bit is 1. A request that matches no device address gives hit = 0, deny = 0 and changes nothing.
- R2: While bit 5 of configuration byte 89h is 0, device address A0h reaches a 128-byte auxiliary store at offsets 00h to 7Fh. Reads are allowed at any level and writes need level 2. While that bit is 1, requests to A0h get no response and have no effect.
- R3: The password entry occupies offsets 7Bh (most significant byte) to 7Eh (least significant byte). It is writable at any level. Every read of it returns FFh with deny = 1.
- R4: level is 2 when the entry equals password 2, is 1 when the entry equals password 1, and is 0 otherwise. After reset the entry holds FFFF_FFFFh, so a password 2 of FFFF_FFFFh gives level 2.
- R5: In table 03h, password 1 sits at B0h to B3h and password 2 at B4h to B7h, most significant byte first. Writes to them need level 2. Reads always return FFh with deny = 1.
- R6: The table select byte at offset 7Fh can be read and written at any level. Offsets 00h to 7Fh decode the same way whatever table is selected.
- R7: While the merge bit is 1, tables 00h and 01h both map offset 80h+n onto auxiliary byte n. They can be read and written at level 1 or above.
- R8: Table 03h offsets 80h to AFh (configuration), table 04h and table 05h offsets 80h to C7h are separate stores that need level 2 for both reads and writes.
- R9: A request to table 02h, to a table above 05h, past the end of a table, to tables 00h/01h while the merge bit is 0, or beyond the current level has no effect on storage, returns FFh and raises deny.
- R10: Offsets 00h to 7Ah of the main device can be read at any level and written only at level 2.
- R11: hit, deny and rdata respond in the clock cycle after the request and hold for that one cycle. Without a request, hit and deny stay 0.
- R12: The access level stays the same until the entry register or a stored password is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, one cycle per byte |
| we | input | 1 | 1 = write, 0 = read |
| dev_addr | input | 8 | Device address byte; bit 0 is ignored |
| reg_addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| hit | output | 1 | Request was addressed to this block |
| deny | output | 1 | Request was refused |
| rdata | output | 8 | Read data, FFh when nothing was read |
| level | output | 2 | Current access level 0, 1 or 2 |

## Verification
On every cycle the assertions check the response framing. Deny only comes with a hit, an idle cycle produces no response, and a refused read returns FFh. They also check that reads of the entry register are always refused and that the level changes only after a write. The bench scenarios are the only way to show address decoding. That covers the two device-address options, folding the auxiliary store into tables 00h and 01h, keeping tables 04h and 05h apart, and the level rules at each tier. They also show the level tracking the comparison while password 2 is rewritten one byte at a time.

// File: rtl/pw_paged_regs.sv
module pw_paged_regs #(
  parameter logic [7:0]  MAIN_DEV  = 8'hA2,
  parameter logic [7:0]  AUX_DEV   = 8'hA0,
  parameter logic [31:0] PW1_INIT  = 32'h1234_5678,
  parameter logic [31:0] PW2_INIT  = 32'hCAFE_F00D,
  parameter int          CFG_BYTES = 48,
  parameter int          LUT_BYTES = 72
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       we,
  input  logic [7:0] dev_addr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] wdata,
  output logic       hit,
  output logic       deny,
  output logic [7:0] rdata,
  output logic [1:0] level
);
  localparam int PW_END = CFG_BYTES + 8;
  localparam logic [6:0] PWE_FIRST = 7'h7B;
  localparam logic [6:0] TSEL_OFF  = 7'h7F;
  localparam logic [6:0] MODE_OFF  = 7'h09;
  localparam logic [6:0] CHIP_OFF  = 7'h0C;

  typedef enum logic [2:0] {RG_NONE, RG_LOW, RG_PWE, RG_TSEL, RG_AUX, RG_CFG, RG_PW, RG_LUT} region_t;

  logic [7:0]  low_m [128];
  logic [7:0]  aux_m [128];
  logic [7:0]  cfg_m [128];
  logic [7:0]  lut_m [2][128];
  logic [31:0] pwe, pw1, pw2;
  logic [7:0]  tsel;

  region_t    rg;
  logic       rd_ok, wr_ok;
  logic [7:0] rd_byte;

  wire [6:0] off      = reg_addr[6:0];
  wire       merge    = cfg_m[MODE_OFF][5];
  wire [7:0] main_dev = cfg_m[MODE_OFF][4] ? cfg_m[CHIP_OFF] : MAIN_DEV;
  wire       sel_main = dev_addr[7:1] == main_dev[7:1];
  wire       sel_aux  = !sel_main && !merge && dev_addr[7:1] == AUX_DEV[7:1];
  wire       go       = req && (sel_main || sel_aux);
  wire       ok       = go && rg != RG_NONE && (we ? wr_ok : rd_ok);
  wire [1:0] pe_slot  = ~(off[1:0] + 2'd1);
  wire [1:0] pw_slot  = ~off[1:0];

  assign level = (pwe == pw2) ? 2'd2 : (pwe == pw1) ? 2'd1 : 2'd0;
  wire lvl1 = level != 2'd0;
  wire lvl2 = level == 2'd2;

  always_comb begin
    rg = RG_NONE; rd_ok = 1'b0; wr_ok = 1'b0;
    if (sel_aux) begin
      if (!reg_addr[7]) begin rg = RG_AUX; rd_ok = 1'b1; wr_ok = lvl2; end
    end else if (!reg_addr[7]) begin
      if (off < PWE_FIRST)      begin rg = RG_LOW;  rd_ok = 1'b1; wr_ok = lvl2; end
      else if (off == TSEL_OFF) begin rg = RG_TSEL; rd_ok = 1'b1; wr_ok = 1'b1; end
      else                      begin rg = RG_PWE;  wr_ok = 1'b1; end
    end else begin
      case (tsel)
        8'h00, 8'h01: if (merge) begin rg = RG_AUX; rd_ok = lvl1; wr_ok = lvl1; end
        8'h03: begin
          if (int'(off) < CFG_BYTES)   begin rg = RG_CFG; rd_ok = lvl2; wr_ok = lvl2; end
          else if (int'(off) < PW_END) begin rg = RG_PW;  wr_ok = lvl2; end
        end
        8'h04, 8'h05: if (int'(off) < LUT_BYTES) begin rg = RG_LUT; rd_ok = lvl2; wr_ok = lvl2; end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rg)
      RG_LOW:  rd_byte = low_m[off];
      RG_TSEL: rd_byte = tsel;
      RG_AUX:  rd_byte = aux_m[off];
      RG_CFG:  rd_byte = cfg_m[off];
      RG_LUT:  rd_byte = lut_m[tsel[0]][off];
      default: rd_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) begin
        low_m[i] <= '0; aux_m[i] <= '0; cfg_m[i] <= '0;
        lut_m[0][i] <= '0; lut_m[1][i] <= '0;
      end
      pwe   <= '1;
      pw1   <= PW1_INIT;
      pw2   <= PW2_INIT;
      tsel  <= '0;
      hit   <= 1'b0;
      deny  <= 1'b0;
      rdata <= 8'hFF;
    end else begin
      hit   <= go;
      deny  <= go && !ok;
      rdata <= (ok && !we) ? rd_byte : 8'hFF;
      if (ok && we) begin
        case (rg)
          RG_LOW:  low_m[off] <= wdata;
          RG_PWE:  pwe[{pe_slot, 3'b000} +: 8] <= wdata;
          RG_TSEL: tsel <= wdata;
          RG_AUX:  aux_m[off] <= wdata;
          RG_CFG:  cfg_m[off] <= wdata;
          RG_LUT:  lut_m[tsel[0]][off] <= wdata;
          RG_PW: begin
            if (off[2]) pw2[{pw_slot, 3'b000} +: 8] <= wdata;
            else        pw1[{pw_slot, 3'b000} +: 8] <= wdata;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pw_paged_regs_chk.sv
module pw_paged_regs_chk #(
  parameter logic [7:0] AUX_DEV = 8'hA0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       we,
  input logic [7:0] dev_addr,
  input logic [7:0] reg_addr,
  input logic       hit,
  input logic       deny,
  input logic [7:0] rdata,
  input logic [1:0] level
);
  assert_deny_implies_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> hit);

  assert_idle_no_response_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!hit && !deny));

  assert_refused_read_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> (!deny || rdata == 8'hFF));

  assert_entry_unreadable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && reg_addr >= 8'h7B && reg_addr <= 8'h7E && dev_addr[7:1] != AUX_DEV[7:1])
    |=> (!hit || (deny && rdata == 8'hFF)));

  assert_level_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && we) |=> $stable(level));

  assert_level_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'd3);
endmodule

bind pw_paged_regs pw_paged_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .dev_addr(dev_addr),
  .reg_addr(reg_addr), .hit(hit), .deny(deny), .rdata(rdata), .level(level)
);

// File: tb/pw_paged_regs_bench.sv
`timescale 1ns/1ps
module pw_paged_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [7:0] dev_addr = 8'h00, reg_addr = 8'h00, wdata = 8'h00;
  logic       hit, deny;
  logic [7:0] rdata;
  logic [1:0] level;

  int checks = 0, errors = 0;
  logic       o_hit, o_deny;
  logic [7:0] o_data;

  always #4 clk = ~clk;

  pw_paged_regs u_pw_paged_regs (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .dev_addr(dev_addr),
    .reg_addr(reg_addr), .wdata(wdata), .hit(hit), .deny(deny),
    .rdata(rdata), .level(level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] d, input logic [7:0] a, input logic w, input logic [7:0] v);
    @(negedge clk);
    req = 1'b1; we = w; dev_addr = d; reg_addr = a; wdata = v;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    o_hit = hit; o_deny = deny; o_data = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    xfer(8'hA2, a, 1'b1, v);
  endtask

  task automatic rd(input logic [7:0] a);
    xfer(8'hA2, a, 1'b0, 8'h00);
  endtask

  task automatic enter_pw(input logic [31:0] p);
    wr(8'h7B, p[31:24]); wr(8'h7C, p[23:16]); wr(8'h7D, p[15:8]); wr(8'h7E, p[7:0]);
  endtask

  task automatic t_reset;
    chk("R4 level after reset", level, 0);
    chk("R11 hit idle", hit, 0);
    chk("R11 deny idle", deny, 0);
  endtask

  task automatic t_level0;
    wr(8'h10, 8'h5A);
    chk("R10 low write at level 0 denied", o_deny, 1);
    rd(8'h10);
    chk("R10 low read at level 0", o_data, 8'h00);
    chk("R10 low read not denied", o_deny, 0);
    rd(8'h7C);
    chk("R3 entry read data", o_data, 8'hFF);
    chk("R3 entry read denied", o_deny, 1);
    wr(8'h7F, 8'h03);
    rd(8'h7F);
    chk("R6 table select at level 0", o_data, 8'h03);
    rd(8'h89);
    chk("R8 config read at level 0 denied", o_deny, 1);
    chk("R9 denied read returns FF", o_data, 8'hFF);
    wr(8'hB0, 8'h00);
    chk("R5 password write at level 0 denied", o_deny, 1);
  endtask

  task automatic t_levels;
    enter_pw(32'h1234_5678);
    chk("R4 password 1 gives level 1", level, 1);
    rd(8'h00);
    chk("R12 level kept after unrelated access", level, 1);
    wr(8'h7E, 8'h00);
    chk("R12 level drops on entry rewrite", level, 0);
    enter_pw(32'hCAFE_F00D);
    chk("R4 password 2 gives level 2", level, 2);
  endtask

  task automatic t_level2_low;
    wr(8'h7F, 8'h04);
    wr(8'h10, 8'h5A);
    rd(8'h10);
    chk("R10 low write at level 2", o_data, 8'h5A);
    wr(8'h7F, 8'h02);
    rd(8'h10);
    chk("R6 low offsets ignore table select", o_data, 8'h5A);
  endtask

  task automatic t_tables;
    wr(8'h7F, 8'h04); wr(8'h90, 8'h11);
    wr(8'h7F, 8'h05); wr(8'h90, 8'h22);
    rd(8'h90);
    chk("R8 table 05 content", o_data, 8'h22);
    wr(8'h7F, 8'h04); rd(8'h90);
    chk("R8 table 04 kept apart", o_data, 8'h11);
    rd(8'hC8);
    chk("R9 past end of table denied", o_deny, 1);
    wr(8'h7F, 8'h02); wr(8'h80, 8'h33);
    chk("R9 table 02 write denied", o_deny, 1);
    rd(8'h80);
    chk("R9 table 02 read FF", o_data, 8'hFF);
    wr(8'h7F, 8'h03); rd(8'hB0);
    chk("R5 password read FF", o_data, 8'hFF);
    chk("R5 password read denied", o_deny, 1);
  endtask

  task automatic t_aux;
    wr(8'h7F, 8'h00); rd(8'h85);
    chk("R9 table 00 absent while separate", o_deny, 1);
    xfer(8'hA0, 8'h05, 1'b1, 8'h77);
    xfer(8'hA0, 8'h05, 1'b0, 8'h00);
    chk("R2 auxiliary device read", o_data, 8'h77);
    chk("R2 auxiliary device hit", o_hit, 1);
    xfer(8'hA0, 8'h85, 1'b0, 8'h00);
    chk("R9 auxiliary upper half denied", o_deny, 1);
    wr(8'h7F, 8'h03); wr(8'h89, 8'h20);
    xfer(8'hA0, 8'h05, 1'b0, 8'h00);
    chk("R2 auxiliary address ignored when merged", o_hit, 0);
    wr(8'h7F, 8'h00); rd(8'h85);
    chk("R7 table 00 maps auxiliary byte", o_data, 8'h77);
    wr(8'h7F, 8'h01); wr(8'h86, 8'h66);
    xfer(8'hA0, 8'h06, 1'b1, 8'h99);
    chk("R2 merged auxiliary write no hit", o_hit, 0);
    wr(8'h7F, 8'h00); rd(8'h86);
    chk("R7 tables 00 and 01 share storage", o_data, 8'h66);
    enter_pw(32'h1234_5678);
    rd(8'h85);
    chk("R7 table 00 read at level 1", o_data, 8'h77);
    wr(8'h7F, 8'h03); rd(8'h89);
    chk("R8 config read at level 1 denied", o_deny, 1);
    enter_pw(32'hCAFE_F00D);
    chk("R4 back to level 2", level, 2);
  endtask

  task automatic t_devaddr;
    xfer(8'hA4, 8'h7F, 1'b0, 8'h00);
    chk("R1 foreign address no hit", o_hit, 0);
    wr(8'h8C, 8'h50); wr(8'h89, 8'h30);
    rd(8'h7F);
    chk("R1 default address dropped", o_hit, 0);
    xfer(8'h50, 8'h7F, 1'b0, 8'h00);
    chk("R1 programmed address answers", o_data, 8'h03);
    xfer(8'h50, 8'h89, 1'b1, 8'h20);
    rd(8'h7F);
    chk("R1 default address restored", o_hit, 1);
    chk("R1 data through restored address", o_data, 8'h03);
  endtask

  task automatic t_pwchange;
    wr(8'hB4, 8'hFF);
    chk("R4 level follows changed password 2", level, 0);
    wr(8'h7B, 8'hFF);
    chk("R4 entry matches new password 2", level, 2);
    wr(8'hB5, 8'hFF); wr(8'h7C, 8'hFF);
    wr(8'hB6, 8'hFF); wr(8'h7D, 8'hFF);
    wr(8'hB7, 8'hFF); wr(8'h7E, 8'hFF);
    chk("R4 all-ones password 2 with all-ones entry", level, 2);
    rd(8'hB4);
    chk("R5 password read denied at level 2", o_deny, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_level0;
    t_levels;
    t_level2_low;
    t_tables;
    t_aux;
    t_devaddr;
    t_pwchange;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule